// File: doc/BRIEF.md
# Sixteen-Bit Load/Store Core with Full-Width Constant Loads

This block is a small multicycle processor core. It has eight 16-bit general registers and a 16-bit program counter. Every instruction is one 16-bit word, and the top six bits of each word select the operation. The core moves data between its registers and a single word-addressed synchronous memory. It does this with register-indirect loads and stores.

A 16-bit instruction word has no room for a 16-bit constant, so the core offers two ways to put a full-width value into a register. The literal load reads a data word placed near the code: it adds a 7-bit signed word offset to the address of the following instruction. The inline immediate reads the very next instruction word as data, and the program counter then steps over that word.

Any other opcode raises the halt flag. The core then stops for good, until reset.

Control is a four-state machine:
- FETCH presents the program counter on the memory port.
- EXEC decodes the returned word and issues the data access.
- WRITEBACK writes the returned data into a register.
- HALT is terminal.

The transitions are:
- FETCH→EXEC always.
- EXEC→FETCH for a store.
- EXEC→WRITEBACK for a load, a literal load or an inline immediate.
- EXEC→HALT for an illegal opcode.
- WRITEBACK→FETCH always.
- HALT→HALT always.

Top module: `lit_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and all eight registers to zero. During reset `mem_we` and `halted` are low, and `mem_addr` is 0.
- R2: The first fetch after reset is issued at address 0. Memory is word-addressed, and read data returns one cycle after the address. The opcode is bits [15:10].
- R3: Opcode 110000 (LOAD) writes mem[reg[A]] into reg[B]. A is bits [9:7], B is bits [6:4], and bits [3:0] are ignored.
- R4: Opcode 110001 (STORE) writes reg[A] to mem[reg[B]], with the same fields as R3. Bits [3:0] are ignored.
- R5: Opcode 110010 (literal load) writes mem[PC+1+sext(off)] into reg[D]. D is bits [9:7] and off is the signed two's-complement word count in bits [6:0], so the reach is -64 to +63 words.
- R6: Opcode 110011 (inline immediate) writes mem[PC+1] into reg[D], with D in bits [9:7]. The next PC is PC+2, so the literal word is never executed, whatever it encodes.
- R7: LOAD, STORE and the literal load leave the next PC at PC+1.
- R8: Any other opcode puts the core in HALT and raises `halted`. From then on, no memory write or register write occurs and the flag stays high until reset.
- R9: A store takes 2 cycles (FETCH, EXEC). A LOAD, a literal load and an inline immediate each take 3 cycles (FETCH, EXEC, WRITEBACK). An illegal opcode raises `halted` 2 cycles after its fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address of the current memory access |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Write strobe for one cycle |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | Illegal opcode seen; core stopped |

## Verification
The literal load is swept over all 128 offsets. The swept offsets include both reach extremes, and the data at the targets differs, so a missing sign extension or a wrong base (PC instead of PC+1) points at a different word. Runs of inline immediates carry literal words that are themselves valid store encodings or the halt encoding. Executing such a literal by mistake would shift the cycle count or corrupt memory. LOAD/STORE round trips use non-zero pad bits and sixteen data values. A sweep over every illegal opcode shows that the core halts and that a store following the illegal word never reaches memory.

// File: rtl/lit_core_pkg.sv
package lit_core_pkg;

    localparam int OP_W  = 6;
    localparam int OFF_W = 7;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 6'b110000,
        OP_STORE = 6'b110001,
        OP_LIT   = 6'b110010,
        OP_IMM   = 6'b110011
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } state_e;

endpackage

// File: rtl/lit_decode.sv
module lit_decode
    import lit_core_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic [W-1:0]     word,
    output logic [AW-1:0]    fld_a,
    output logic [AW-1:0]    fld_b,
    output logic [OFF_W-1:0] fld_off,
    output logic             is_load,
    output logic             is_store,
    output logic             is_lit,
    output logic             is_imm,
    output logic             is_illegal
);
    localparam int OP_LO = W - OP_W;
    localparam int A_LO  = OP_LO - AW;
    localparam int B_LO  = A_LO - AW;

    logic [OP_W-1:0] op;

    assign op      = word[W-1:OP_LO];
    assign fld_a   = word[OP_LO-1:A_LO];
    assign fld_b   = word[A_LO-1:B_LO];
    assign fld_off = word[OFF_W-1:0];

    always_comb begin
        is_load    = 1'b0;
        is_store   = 1'b0;
        is_lit     = 1'b0;
        is_imm     = 1'b0;
        is_illegal = 1'b0;
        unique case (op)
            OP_LOAD:  is_load  = 1'b1;
            OP_STORE: is_store = 1'b1;
            OP_LIT:   is_lit   = 1'b1;
            OP_IMM:   is_imm   = 1'b1;
            default:  is_illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/lit_regfile.sv
module lit_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (we && waddr == AW'(g)) begin
                q[g] <= wdata;
            end
        end

        // R3
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(we && waddr == AW'(g)) |=> q[g] == $past(q[g]));
    end

    assign rdata_a = q[raddr_a];
    assign rdata_b = q[raddr_b];

endmodule

// File: rtl/lit_ctrl.sv
module lit_ctrl
    import lit_core_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     mem_rdata,
    input  logic [AW-1:0]    fld_a,
    input  logic [AW-1:0]    fld_b,
    input  logic [OFF_W-1:0] fld_off,
    input  logic             is_load,
    input  logic             is_store,
    input  logic             is_lit,
    input  logic             is_imm,
    input  logic             is_illegal,
    input  logic [W-1:0]     rd_a,
    input  logic [W-1:0]     rd_b,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    output logic             mem_we,
    output logic             rf_we,
    output logic [AW-1:0]    rf_waddr,
    output logic [W-1:0]     rf_wdata,
    output logic             halted
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    state_e       state, state_nx;
    logic [W-1:0] pc;
    logic [AW-1:0] dst_q;
    logic         long_q;
    logic [W-1:0] pc_next_insn;
    logic [W-1:0] lit_addr;

    assign pc_next_insn = pc + ONE;
    assign lit_addr     = pc_next_insn + {{(W-OFF_W){fld_off[OFF_W-1]}}, fld_off};

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (is_illegal)    state_nx = ST_HALT;
                else if (is_store) state_nx = ST_FETCH;
                else               state_nx = ST_WB;
            end
            ST_WB:   state_nx = ST_FETCH;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_addr  = pc;
        mem_wdata = rd_a;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_waddr  = dst_q;
        rf_wdata  = mem_rdata;
        halted    = 1'b0;
        unique case (state)
            ST_FETCH: mem_addr = pc;
            ST_EXEC: begin
                if (is_load)       mem_addr = rd_a;
                else if (is_store) begin
                    mem_addr = rd_b;
                    mem_we   = 1'b1;
                end
                else if (is_lit)   mem_addr = lit_addr;
                else if (is_imm)   mem_addr = pc_next_insn;
            end
            ST_WB:   rf_we  = 1'b1;
            ST_HALT: halted = 1'b1;
            default: halted = 1'b1;
        endcase
    end

    // program counter and write-back target
    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            dst_q  <= '0;
            long_q <= 1'b0;
        end else begin
            unique case (state)
                ST_EXEC: begin
                    if (is_store) pc <= pc_next_insn;
                    dst_q  <= is_load ? fld_b : fld_a;
                    long_q <= is_imm;
                end
                ST_WB:   pc <= pc + (long_q ? TWO : ONE);
                default: pc <= pc;
            endcase
        end
    end

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !rf_we));

    // R7
    store_next_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (state == ST_FETCH && mem_addr == $past(pc) + ONE));

    // R6
    imm_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && is_imm) |=> ##1 (mem_addr == $past(pc, 2) + TWO));

    // R9
    wb_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && (is_load || is_lit || is_imm)) |=> rf_we);

endmodule

// File: rtl/lit_core.sv
module lit_core
    import lit_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    localparam int AW = $clog2(NREG);

    logic [AW-1:0]     fld_a, fld_b, rf_waddr;
    logic [OFF_W-1:0]  fld_off;
    logic              is_load, is_store, is_lit, is_imm, is_illegal;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata, rd_a, rd_b;

    lit_decode #(.W(DATA_W), .AW(AW)) u_dec (
        .word       (mem_rdata),
        .fld_a      (fld_a),
        .fld_b      (fld_b),
        .fld_off    (fld_off),
        .is_load    (is_load),
        .is_store   (is_store),
        .is_lit     (is_lit),
        .is_imm     (is_imm),
        .is_illegal (is_illegal)
    );

    lit_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (fld_a),
        .raddr_b (fld_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    lit_ctrl #(.W(DATA_W), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mem_rdata  (mem_rdata),
        .fld_a      (fld_a),
        .fld_b      (fld_b),
        .fld_off    (fld_off),
        .is_load    (is_load),
        .is_store   (is_store),
        .is_lit     (is_lit),
        .is_imm     (is_imm),
        .is_illegal (is_illegal),
        .rd_a       (rd_a),
        .rd_b       (rd_b),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .halted     (halted)
    );

endmodule

// File: tb/lit_core_test.sv
module lit_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, halted;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    logic [15:0] mem  [256];
    logic [15:0] img  [256];
    logic [15:0] rmem [256];
    logic [15:0] rreg [8];

    int checks = 0;
    int fails  = 0;
    bit first_run = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    lit_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [15:0] enc_ls(logic [5:0] op, int a, int b, logic [3:0] pad);
        return {op, 3'(a), 3'(b), pad};
    endfunction
    function automatic logic [15:0] enc_lit(int d, int off);
        return {6'b110010, 3'(d), 7'(off)};
    endfunction
    function automatic logic [15:0] enc_imm(int d);
        return {6'b110011, 3'(d), 7'h00};
    endfunction
    function automatic logic [15:0] pat(int a);
        return 16'(a * 257) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill_img();
        for (int a = 0; a < 256; a++) img[a] = pat(a);
    endtask

    task automatic ref_run(output int cyc);
        logic [15:0] pc, ins, ea;
        bit done;
        for (int a = 0; a < 256; a++) rmem[a] = img[a];
        for (int r = 0; r < 8; r++) rreg[r] = '0;
        pc = '0; cyc = 0; done = 1'b0;
        for (int s = 0; s < 300 && !done; s++) begin
            ins = rmem[pc[7:0]];
            case (ins[15:10])
                6'b110000: begin rreg[ins[6:4]] = rmem[rreg[ins[9:7]][7:0]]; pc = pc + 1; cyc += 3; end
                6'b110001: begin rmem[rreg[ins[6:4]][7:0]] = rreg[ins[9:7]]; pc = pc + 1; cyc += 2; end
                6'b110010: begin
                    ea = pc + 16'd1 + {{9{ins[6]}}, ins[6:0]};
                    rreg[ins[9:7]] = rmem[ea[7:0]]; pc = pc + 1; cyc += 3;
                end
                6'b110011: begin
                    ea = pc + 16'd1;
                    rreg[ins[9:7]] = rmem[ea[7:0]]; pc = pc + 2; cyc += 3;
                end
                default: begin cyc += 2; done = 1'b1; end
            endcase
        end
    endtask

    task automatic run_dut(output int cyc);
        int bad;
        rst = 1'b1;
        for (int a = 0; a < 256; a++) begin
            ld_en = 1'b1; ld_addr = 8'(a); ld_data = img[a];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        if (first_run) begin
            chk(mem_addr == 16'h0000, "R1 reset addr", mem_addr, 16'h0000);
            chk(mem_we == 1'b0, "R1 reset we", 16'(mem_we), 16'h0);
            chk(halted == 1'b0, "R1 reset halted", 16'(halted), 16'h0);
        end
        rst = 1'b0;
        #1;
        if (first_run) chk(mem_addr == 16'h0000, "R2 first fetch", mem_addr, 16'h0000);
        first_run = 1'b0;
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) chk(1'b0, "R9 run did not halt", 16'(cyc), 16'd400);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (mem_we || !halted) bad++;
        end
        chk(bad == 0, "R8 quiet after halt", 16'(bad), 16'd0);
    endtask

    task automatic image_chk(input string tag);
        int mism = 0;
        logic [15:0] a_act = '0, a_exp = '0;
        for (int a = 0; a < 256; a++) begin
            if (mem[a] !== rmem[a]) begin
                if (mism == 0) begin a_act = mem[a]; a_exp = rmem[a]; end
                mism++;
            end
        end
        chk(mism == 0, tag, a_act, a_exp);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL R9 watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int dc, rc;
        logic [15:0] v;
        int p;

        // Reset state: registers zero (R1)
        fill_img();
        img[0] = enc_ls(6'b110001, 5, 6, 4'h0);
        img[1] = 16'h0000;
        ref_run(rc);
        run_dut(dc);
        chk(mem[0] == 16'h0000, "R1 regs zero after reset", mem[0], 16'h0000);
        chk(dc == 4, "R9 store+halt cycles", 16'(dc), 16'd4);

        // Literal load sweep over all offsets (R5)
        for (int off = -64; off <= 63; off++) begin
            fill_img();
            img[0] = enc_imm(2);
            img[1] = 16'h00F0;
            img[2] = enc_lit(1, off);
            img[3] = enc_ls(6'b110001, 1, 2, 4'h0);
            img[4] = 16'h0000;
            ref_run(rc);
            run_dut(dc);
            chk(mem[8'hF0] == rmem[8'hF0], "R5 literal sweep", mem[8'hF0], rmem[8'hF0]);
            chk(dc == 10 && rc == 10, "R9 literal cycles", 16'(dc), 16'd10);
            if (off == -64) chk(mem[8'hF0] == pat(195), "R5 offset -64", mem[8'hF0], pat(195));
            if (off == 63)  chk(mem[8'hF0] == pat(66),  "R5 offset +63", mem[8'hF0], pat(66));
            image_chk("R7 literal image");
        end

        // Inline immediates followed by more code (R6)
        for (int k = 0; k < 16; k++) begin
            fill_img();
            p = 0;
            for (int r = 0; r < 7; r++) begin
                v = (k == 1 && r == 3) ? 16'h0000 : (16'(k * 16'h1111 + r * 16'h0F0F) ^ 16'hC4A0);
                img[p] = enc_imm(7);   img[p+1] = 16'(8'hC0 + r);
                img[p+2] = enc_imm(r); img[p+3] = v;
                img[p+4] = enc_ls(6'b110001, r, 7, 4'h0);
                p += 5;
            end
            img[p] = enc_imm(7); img[p+1] = 16'h00C7;
            img[p+2] = enc_ls(6'b110001, 7, 7, 4'h0);
            img[p+3] = 16'h0000;
            ref_run(rc);
            run_dut(dc);
            for (int r = 0; r < 7; r++) begin
                v = (k == 1 && r == 3) ? 16'h0000 : (16'(k * 16'h1111 + r * 16'h0F0F) ^ 16'hC4A0);
                chk(mem[8'hC0 + r] == v, "R6 immediate value", mem[8'hC0 + r], v);
            end
            chk(mem[8'hC7] == 16'h00C7, "R6 immediate R7", mem[8'hC7], 16'h00C7);
            chk(dc == 63 && rc == 63, "R6 literal word skipped (cycles)", 16'(dc), 16'd63);
            image_chk("R6 immediate image");
        end

        // LOAD/STORE round trip, pad bits non-zero (R3, R4)
        for (int k = 0; k < 16; k++) begin
            fill_img();
            v = 16'(k * 16'h1357) ^ 16'hC4B1;
            img[0] = enc_imm(1); img[1] = 16'h0080;
            img[2] = enc_imm(2); img[3] = 16'h00A0;
            img[4] = enc_imm(3); img[5] = v;
            img[6] = enc_ls(6'b110001, 3, 1, 4'hF);
            img[7] = enc_ls(6'b110000, 1, 4, 4'h5);
            img[8] = enc_ls(6'b110001, 4, 2, 4'hA);
            img[9] = 16'h0000;
            ref_run(rc);
            run_dut(dc);
            chk(mem[8'h80] == v, "R4 store value", mem[8'h80], v);
            chk(mem[8'hA0] == v, "R3 load round trip", mem[8'hA0], v);
            chk(dc == 18, "R9 round trip cycles", 16'(dc), 16'd18);
            image_chk("R3 round trip image");
        end

        // Every illegal opcode halts (R8)
        for (int op = 0; op < 64; op++) begin
            if (op >= 48 && op <= 51) continue;
            fill_img();
            img[0] = {6'(op), 10'h3FF};
            img[1] = enc_ls(6'b110001, 0, 0, 4'h0);
            ref_run(rc);
            run_dut(dc);
            chk(dc == 2, "R8 illegal halt cycles", 16'(dc), 16'd2);
            chk(mem[0] == img[0], "R8 no store after halt", mem[0], img[0]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule